// File: doc/BRIEF.md
# Pipelined Separate-Port SRAM with Pass-Through

A single-clock synchronous memory with an input data port and a separate output data port. On a rising clock edge it captures the address, input word, write strobe, pass-through strobe and two chip selects. The operation chosen by those controls completes at the next rising edge, which loads a registered output. That output then carries either the stored word as it was before the operation or the captured input word. A write, when requested, lands in the array at that same edge. Reads therefore always see the old contents of the location before the new word replaces it.

The pass-through strobe steers the captured input word to the output in place of the array word. This can be done alongside a write or instead of one, which lets a switch buffer forward a cell while storing it. A level-sensitive output enable gates the output at once, independent of the clock. High impedance is represented by a drive-valid flag next to a data bus that reads zero whenever it is not driven. Address and data widths are parameters. The default is 1K words of 18 bits so that elaboration stays small; larger depths are set through the address width.

Top module: `ptsram`

## Requirements
- R1: Inputs sampled at clock edge n produce their output at edge n+1; the output does not change in response to them before edge n+1.
- R2: The block is selected only when `ce1_n` is 0 and `ce2` is 1; any other combination deselects the cycle.
- R3: Selected with `wr_n`=0 and `pt_n`=0: the input word is stored at the address and the same input word appears on `dout`.
- R4: Selected with `wr_n`=0 and `pt_n`=1: `dout` shows the word stored at the address before this cycle, and the input word is then stored there.
- R5: Selected with `wr_n`=1 and `pt_n`=0: the input word appears on `dout` and the array is left unchanged.
- R6: Selected with `wr_n`=1 and `pt_n`=1: `dout` shows the stored word at the address and nothing is written.
- R7: A deselected cycle writes nothing, so its input word is dropped, and `dout_en` is 0 after the next edge.
- R8: `oe_n`=1 forces `dout_en` to 0 and `dout` to zero immediately; `oe_n`=0 lets the registered result drive again without a clock edge.
- R9: Operations run back to back with no idle cycles, and a read of an address written in the previous cycle returns the new word.
- R10: While `rst_n` is 0 and after reset until a selected operation completes, `dout_en` is 0; `dout` is zero whenever `dout_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low; clears the pipeline valid state |
| ce1_n | input | 1 | Chip select, active low |
| ce2 | input | 1 | Chip select, active high |
| wr_n | input | 1 | Write strobe, active low |
| pt_n | input | 1 | Pass-through strobe, active low |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Input word |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dout | output | DATA_W | Output word; zero when not driven |
| dout_en | output | 1 | Output drive valid (low models high impedance) |

## Verification
The checker assumes the bench holds the block deselected while reset is asserted. It also assumes `oe_n` is low at every rising edge, so two-edge-old control values describe the word currently on the bus. The bench drives all inputs on falling edges and keeps every `oe_n` pulse within half a cycle. Array contents are never checked at an address the reference model has not written; a read of such an address checks only the drive-valid flag.

// File: rtl/ptsram.sv
module ptsram #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              wr_n,
  input  logic              pt_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              oe_n,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] a_r;
  logic [DATA_W-1:0] d_r, q_r;
  logic              sel_r, we_r, pt_r, vld_r;

  wire sel = !ce1_n && ce2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_r <= 1'b0;
      we_r  <= 1'b0;
      pt_r  <= 1'b0;
      vld_r <= 1'b0;
      q_r   <= '0;
    end else begin
      sel_r <= sel;
      we_r  <= !wr_n;
      pt_r  <= !pt_n;
      vld_r <= sel_r;
      if (sel_r) q_r <= pt_r ? d_r : mem[a_r];
    end
  end

  always_ff @(posedge clk) begin
    if (sel) begin
      a_r <= addr;
      d_r <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (sel_r && we_r) mem[a_r] <= d_r;
  end

  assign dout_en = !oe_n && vld_r;
  assign dout    = dout_en ? q_r : '0;
endmodule

// File: rtl/ptsram_chk.sv
module ptsram_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce1_n,
  input logic              ce2,
  input logic              pt_n,
  input logic [DATA_W-1:0] din,
  input logic              oe_n,
  input logic [DATA_W-1:0] dout,
  input logic              dout_en
);
  logic [1:0] age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R3
  pass_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && $past(!ce1_n && ce2 && !pt_n, 2) && !oe_n) |-> (dout_en && dout == $past(din, 2)));

  // R7
  desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && $past(ce1_n || !ce2, 2)) |-> !dout_en);

  // R8
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (!dout_en && dout == '0));

  // R10
  rst_idle_chk: assert property (@(posedge clk)
    !rst_n |=> (!dout_en && dout == '0));
endmodule

bind ptsram ptsram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2(ce2), .pt_n(pt_n),
  .din(din), .oe_n(oe_n), .dout(dout), .dout_en(dout_en)
);

// File: tb/test_ptsram.sv
module test_ptsram;
  localparam int AW = 10;
  localparam int DW = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce1_n = 1'b1, ce2 = 1'b0, wr_n = 1'b1, pt_n = 1'b1, oe_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          dout_en;

  int nchk = 0;
  int nfail = 0;

  typedef struct {
    bit            en;
    bit            known;
    logic [DW-1:0] d;
    string         tag;
    bit            oe_test;
  } exp_t;

  exp_t          expq[$];
  logic [DW-1:0] ref_mem [int];

  ptsram #(.ADDR_W(AW), .DATA_W(DW)) i_ptsram (
    .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2(ce2), .wr_n(wr_n), .pt_n(pt_n),
    .addr(addr), .din(din), .oe_n(oe_n), .dout(dout), .dout_en(dout_en)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic settle_check();
    exp_t e;
    if (expq.size() == 2) begin
      e = expq.pop_front();
      check(dout_en == e.en, {e.tag, " drive-valid"}, DW'(dout_en), DW'(e.en));
      if (e.en && e.known) check(dout == e.d, {e.tag, " data"}, dout, e.d);
      if (!e.en) check(dout == '0, {e.tag, " idle bus R10"}, dout, '0);
      if (e.oe_test && e.en) begin
        oe_n = 1'b1;
        #1;
        check(!dout_en && dout == '0, "R8 oe high forces off", dout, '0);
        oe_n = 1'b0;
        #1;
        check(dout_en && (!e.known || dout == e.d), "R8 oe low restores", dout, e.d);
      end
    end
  endtask

  task automatic op(input bit c1n, input bit c2, input bit w, input bit p,
                    input int a, input logic [DW-1:0] d, input string tag, input bit oet = 0);
    exp_t e;
    bit s;
    @(negedge clk);
    settle_check();
    s = !c1n && c2;
    ce1_n = c1n; ce2 = c2; wr_n = !w; pt_n = !p; addr = AW'(a); din = d;
    e.en = s; e.known = 1'b1; e.d = '0; e.tag = tag; e.oe_test = oet;
    if (s) begin
      if (p) e.d = d;
      else if (ref_mem.exists(a)) e.d = ref_mem[a];
      else e.known = 1'b0;
      if (w) ref_mem[a] = d;
    end
    expq.push_back(e);
  endtask

  initial begin
    #1_000_000;
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 1, 0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!dout_en && dout == '0, "R10 reset state", dout, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!dout_en, "R10 after reset", DW'(dout_en), '0);

    for (int i = 0; i < 8; i++) op(0, 1, 1, 0, i, DW'(18'h100 + i), "R4 first fill");
    for (int i = 0; i < 8; i++) op(0, 1, 0, 0, i, DW'(18'h3ffff), "R6 read back", i == 2);

    op(0, 1, 1, 0, 3, 18'h2aaaa, "R4 read-before-write old word");
    op(0, 1, 0, 0, 3, 18'h0, "R9 read right after write");

    // R1: output must still hold the previous result one edge after capture
    op(0, 1, 0, 0, 1, 18'h0, "R1 plain read");
    op(0, 1, 0, 1, 9, 18'h12345, "R5 pass only");
    @(negedge clk);
    check(dout == 18'h101, "R1 no early update", dout, 18'h101);
    expq.pop_front();
    expq.pop_front();

    op(0, 1, 1, 1, 5, 18'h15555, "R3 write and pass");
    op(0, 1, 0, 0, 5, 18'h0, "R3 stored word");
    op(0, 1, 0, 1, 6, 18'h0beef, "R5 pass shows input");
    op(0, 1, 0, 0, 6, 18'h0, "R5 array unchanged");

    op(1, 1, 1, 0, 7, 18'h3c3c3, "R7 deselect ce1_n high");
    op(0, 0, 1, 1, 7, 18'h0c3c3, "R2 deselect ce2 low");
    op(1, 0, 1, 0, 7, 18'h11111, "R2 deselect both");
    op(0, 1, 0, 0, 7, 18'h0, "R7 dropped write");

    for (int i = 0; i < 300; i++) begin
      int r;
      r = int'($urandom_range(0, 9));
      if (r < 1) op(1, 1, 1, 0, i % 16, DW'($urandom), "R9 R2 mixed deselect");
      else op(0, 1, r[0], (r % 3) == 0, int'($urandom_range(0, 15)), DW'($urandom),
              "R1 R9 mixed stream", (i % 37) == 0);
    end

    for (int i = 0; i < 3; i++) op(1, 0, 0, 0, 0, '0, "R7 drain");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule